// File: doc/BRIEF.md
# LCD Display Mode Controller

This block is the control stage that sits in front of a segment LCD waveform generator. It holds three settings: a display mode, a 4-bit contrast code and a polarity bit. Software writes these through a small register port. A stream of pixel words read from display memory passes through the block. Each bit of each word leaves as the on/off value the waveform generator must drive. The block also drives three plain control pins: the common-drive style, an enable for the drive-voltage regulator, and the contrast code for that regulator.

The display mode chooses one of four behaviours. The panel can be dark with the regulator stopped. It can show memory contents. It can light every segment, which uses dynamic common drive. It can blank every segment, which uses static common drive. Display memory is never changed, so software can blink the panel by switching between modes. A sleep request forces the effective mode to "off". When the request is released, the saved mode returns. Writes made during sleep go to the saved mode.

The pixel path uses valid/ready on both sides and holds one word. An input word is accepted when `pix_in_valid` and `pix_in_ready` are both high on a clock edge. `pix_in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `pix_out_valid` is high and `pix_out_ready` is low, the output word is held and no new word is taken.

Top module: `lcd_mode_ctrl`

## Requirements
- R1: After reset: mode reads 0, polarity bit reads 1, contrast reads 7, `reg_en` is 0, `com_dynamic` is 1, `pix_out_valid` is 0 and `pix_in_ready` is 1.
- R2: Register address 0 holds the mode in bits [1:0] and the polarity bit in bit 4; address 1 holds the contrast in bits [3:0]; every other bit and address reads 0. A write takes effect at the clock edge that samples it, and reads are combinational from the current value.
- R3: In mode 0 (off), `reg_en` is 0 and every pixel accepted leaves as 0. In modes 1, 2 and 3, `reg_en` is 1.
- R4: In mode 1 (normal), each output bit equals the input bit when the polarity bit is 1, and equals its complement when the polarity bit is 0.
- R5: In mode 2 (all lit), every output bit is 1 with polarity bit 1 and 0 with polarity bit 0, and `com_dynamic` is 1.
- R6: In mode 3 (all blank), every output bit is 0 whatever the polarity bit, and `com_dynamic` is 0 (static). Modes 0, 1 and 2 give `com_dynamic` 1.
- R7: One cycle after `sleep_req` is sampled high, the mode reads 0, `reg_en` is 0 and pixels leave as 0. Contrast and the polarity bit are unchanged.
- R8: One cycle after `sleep_req` is sampled low again, the mode from before sleep is in effect and reads back.
- R9: A mode write while sleep is in effect, including in the cycle that sleep begins, leaves the effective mode at 0. The written mode is the one in effect after wake.
- R10: An accepted word appears on `pix_out_data` with `pix_out_valid` high one cycle later. While `pix_out_valid` is high and `pix_out_ready` is low, the word stays stable and `pix_in_ready` is low.
- R11: A word is mapped with the settings in effect in the cycle it is accepted. A setting written in that cycle or later does not alter it.
- R12: The `contrast` output follows the contrast register, and it changes only when address 1 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| sleep_req | input | 1 | High while the system is asleep |
| pix_in_valid | input | 1 | Input pixel word valid |
| pix_in_ready | output | 1 | Block can accept an input word |
| pix_in_data | input | PIX_W | Pixel bits from display memory |
| pix_out_valid | output | 1 | Output pixel word valid |
| pix_out_ready | input | 1 | Waveform generator takes the output word |
| pix_out_data | output | PIX_W | Effective segment on/off bits |
| com_dynamic | output | 1 | 1 = dynamic common drive, 0 = static |
| reg_en | output | 1 | Drive-voltage regulator enable |
| contrast | output | 4 | Contrast code, higher is darker |

## Verification
Two pairs of functions can fall in the same clock edge. In the first pair, sleep begins in the same cycle as a mode write. The bench raises `sleep_req` and issues the write on the same edge. It then expects the mode to read 0 during sleep and the written mode to take effect after wake. In the second pair, a pixel word is accepted in the same cycle as a mode write. The bench expects that word to carry the old mapping. It also stalls the output across a later mode change to confirm that the held word does not change.

// File: rtl/lcd_mode_pkg.sv
`timescale 1ns/1ps
package lcd_mode_pkg;
  localparam int CFG_AW  = 2;
  localparam int CFG_DW  = 8;
  localparam int CON_W   = 4;
  localparam int POL_BIT = 4;

  localparam logic [CFG_AW-1:0] ADDR_CTRL     = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_CONTRAST = 2'd1;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_ALL_ON  = 2'd2,
    MODE_ALL_OFF = 2'd3
  } disp_mode_e;

  typedef struct packed {
    disp_mode_e mode;
    logic       pol_n;
  } pix_cfg_t;
endpackage

// File: rtl/lcd_cfg_regs.sv
`timescale 1ns/1ps
module lcd_cfg_regs
  import lcd_mode_pkg::*;
#(
  parameter logic [CON_W-1:0] CON_RESET = 4'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              sleep_req,
  output pix_cfg_t          cfg_eff,
  output logic [CON_W-1:0]  contrast
);
  disp_mode_e       mode_saved;
  logic             pol_n_q;
  logic             sleep_q;
  logic [CON_W-1:0] con_q;
  disp_mode_e       mode_eff;
  logic             wdata_unused;

  assign wdata_unused = ^{cfg_wdata[CFG_DW-1:POL_BIT+1], cfg_wdata[POL_BIT-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_saved <= MODE_OFF;
      pol_n_q    <= 1'b1;
      con_q      <= CON_RESET;
      sleep_q    <= 1'b0;
    end else begin
      sleep_q <= sleep_req;
      if (cfg_we && cfg_addr == ADDR_CTRL) begin
        mode_saved <= disp_mode_e'(cfg_wdata[1:0]);
        pol_n_q    <= cfg_wdata[POL_BIT];
      end
      if (cfg_we && cfg_addr == ADDR_CONTRAST)
        con_q <= cfg_wdata[CON_W-1:0];
    end
  end

  assign mode_eff      = sleep_q ? MODE_OFF : mode_saved;
  assign cfg_eff.mode  = mode_eff;
  assign cfg_eff.pol_n = pol_n_q;
  assign contrast      = con_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_CTRL: begin
        cfg_rdata[1:0]     = mode_eff;
        cfg_rdata[POL_BIT] = pol_n_q;
      end
      ADDR_CONTRAST: cfg_rdata[CON_W-1:0] = con_q;
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcd_pix_map.sv
`timescale 1ns/1ps
module lcd_pix_map
  import lcd_mode_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  pix_cfg_t         cfg,
  input  logic [PIX_W-1:0] mem_bits,
  output logic [PIX_W-1:0] seg_bits
);
  logic inv;
  assign inv = ~cfg.pol_n;

  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    always_comb begin
      case (cfg.mode)
        MODE_NORMAL:  seg_bits[i] = mem_bits[i] ^ inv;
        MODE_ALL_ON:  seg_bits[i] = ~inv;
        MODE_ALL_OFF: seg_bits[i] = 1'b0;
        default:      seg_bits[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pix_stage.sv
`timescale 1ns/1ps
module lcd_pix_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/lcd_mode_ctrl.sv
`timescale 1ns/1ps
module lcd_mode_ctrl
  import lcd_mode_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             sleep_req,
  input  logic             pix_in_valid,
  output logic             pix_in_ready,
  input  logic [PIX_W-1:0] pix_in_data,
  output logic             pix_out_valid,
  input  logic             pix_out_ready,
  output logic [PIX_W-1:0] pix_out_data,
  output logic             com_dynamic,
  output logic             reg_en,
  output logic [3:0]       contrast
);
  pix_cfg_t         cfg_eff;
  logic [PIX_W-1:0] seg_bits;

  lcd_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sleep_req (sleep_req),
    .cfg_eff   (cfg_eff),
    .contrast  (contrast)
  );

  lcd_pix_map #(.PIX_W(PIX_W)) u_map (
    .cfg      (cfg_eff),
    .mem_bits (pix_in_data),
    .seg_bits (seg_bits)
  );

  lcd_pix_stage #(.W(PIX_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_in_valid),
    .in_ready  (pix_in_ready),
    .in_data   (seg_bits),
    .out_valid (pix_out_valid),
    .out_ready (pix_out_ready),
    .out_data  (pix_out_data)
  );

  assign reg_en      = (cfg_eff.mode != MODE_OFF);
  assign com_dynamic = (cfg_eff.mode != MODE_ALL_OFF);
endmodule

// File: rtl/lcd_mode_ctrl_chk.sv
`timescale 1ns/1ps
module lcd_mode_ctrl_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [7:0]       cfg_wdata,
  input logic             sleep_req,
  input logic             pix_in_valid,
  input logic             pix_in_ready,
  input logic             pix_out_valid,
  input logic             pix_out_ready,
  input logic [PIX_W-1:0] pix_out_data,
  input logic             com_dynamic,
  input logic             reg_en,
  input logic [3:0]       contrast
);
  logic fire;
  assign fire = pix_in_valid && pix_in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_valid && !pix_out_ready |=> pix_out_valid && $stable(pix_out_data)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_valid && !pix_out_ready |-> !pix_in_ready); // R10
  AST_ACCEPT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pix_out_valid); // R10
  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !reg_en |=> pix_out_data == '0); // R3
  AST_STATIC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !com_dynamic |=> pix_out_data == '0); // R6
  AST_STATIC_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !com_dynamic |-> reg_en); // R6
  AST_SLEEP_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !reg_en); // R7
  AST_CONTRAST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 2'd1 |=> contrast == $past(cfg_wdata[3:0])); // R12
  AST_CONTRAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 2'd1) |=> $stable(contrast)); // R12
endmodule

bind lcd_mode_ctrl lcd_mode_ctrl_chk #(.PIX_W(PIX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .cfg_wdata     (cfg_wdata),
  .sleep_req     (sleep_req),
  .pix_in_valid  (pix_in_valid),
  .pix_in_ready  (pix_in_ready),
  .pix_out_valid (pix_out_valid),
  .pix_out_ready (pix_out_ready),
  .pix_out_data  (pix_out_data),
  .com_dynamic   (com_dynamic),
  .reg_en        (reg_en),
  .contrast      (contrast)
);

// File: tb/lcd_mode_ctrl_test.sv
`timescale 1ns/1ps
module lcd_mode_ctrl_test;
  localparam int PIX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [7:0]       cfg_wdata = '0;
  logic [7:0]       cfg_rdata;
  logic             sleep_req = 1'b0;
  logic             pix_in_valid = 1'b0;
  logic             pix_in_ready;
  logic [PIX_W-1:0] pix_in_data = '0;
  logic             pix_out_valid;
  logic             pix_out_ready = 1'b1;
  logic [PIX_W-1:0] pix_out_data;
  logic             com_dynamic;
  logic             reg_en;
  logic [3:0]       contrast;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lcd_mode_ctrl #(.PIX_W(PIX_W)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic send(string req, logic [7:0] d, logic [7:0] exp);
    pix_out_ready = 1'b1; pix_in_valid = 1'b1; pix_in_data = d;
    @(negedge clk);
    pix_in_valid = 1'b0;
    chk({req, " out_valid"}, 32'(pix_out_valid), 32'd1);
    chk({req, " out_data"}, 32'(pix_out_data), 32'(exp));
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rd(2'd0, r); chk("R1 ctrl reg", 32'(r), 32'h10);
    rd(2'd1, r); chk("R1 contrast reg", 32'(r), 32'h07);
    chk("R1 reg_en", 32'(reg_en), 32'd0);
    chk("R1 com_dynamic", 32'(com_dynamic), 32'd1);
    chk("R1 out_valid", 32'(pix_out_valid), 32'd0);
    chk("R1 in_ready", 32'(pix_in_ready), 32'd1);
    chk("R12 contrast pin", 32'(contrast), 32'd7);
    send("R3 off pixel", 8'hFF, 8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] r;
    wr(2'd0, 8'h11);
    rd(2'd0, r); chk("R2 ctrl readback", 32'(r), 32'h11);
    chk("R3 reg_en normal", 32'(reg_en), 32'd1);
    send("R4 normal", 8'hA5, 8'hA5);
    wr(2'd0, 8'h01);
    send("R4 normal inverted", 8'hA5, 8'h5A);
    chk("R6 com_dynamic normal", 32'(com_dynamic), 32'd1);
  endtask

  task automatic t_forced();
    wr(2'd0, 8'h12);
    send("R5 all lit", 8'h3C, 8'hFF);
    chk("R5 com_dynamic", 32'(com_dynamic), 32'd1);
    wr(2'd0, 8'h02);
    send("R5 all lit inverted", 8'h3C, 8'h00);
    wr(2'd0, 8'h13);
    send("R6 all blank", 8'h3C, 8'h00);
    chk("R6 com static", 32'(com_dynamic), 32'd0);
    chk("R3 reg_en blank", 32'(reg_en), 32'd1);
    wr(2'd0, 8'h03);
    send("R6 blank ignores inversion", 8'hC3, 8'h00);
    wr(2'd0, 8'h11);
    send("R4 after blink", 8'h3C, 8'h3C);
  endtask

  task automatic t_contrast();
    logic [7:0] r;
    wr(2'd1, 8'hFC);
    rd(2'd1, r); chk("R2 contrast readback", 32'(r), 32'h0C);
    chk("R12 contrast pin", 32'(contrast), 32'hC);
    rd(2'd2, r); chk("R2 unmapped addr", 32'(r), 32'h00);
    wr(2'd0, 8'h12);
    chk("R12 contrast kept", 32'(contrast), 32'hC);
    wr(2'd1, 8'h00);
    chk("R12 contrast zero", 32'(contrast), 32'h0);
  endtask

  task automatic t_sleep();
    logic [7:0] r;
    wr(2'd0, 8'h02);
    sleep_req = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R7 mode reads off", 32'(r), 32'h00);
    chk("R7 reg_en", 32'(reg_en), 32'd0);
    chk("R7 contrast kept", 32'(contrast), 32'h0);
    send("R7 sleep pixel", 8'hFF, 8'h00);
    sleep_req = 1'b0;
    @(negedge clk);
    rd(2'd0, r); chk("R8 mode restored", 32'(r), 32'h02);
    chk("R8 reg_en", 32'(reg_en), 32'd1);
    send("R8 restored lit inverted", 8'h55, 8'h00);
  endtask

  task automatic t_sleep_write();
    logic [7:0] r;
    wr(2'd0, 8'h11);
    sleep_req = 1'b1;
    wr(2'd0, 8'h13);
    rd(2'd0, r); chk("R9 off while asleep", 32'(r), 32'h10);
    chk("R9 reg_en asleep", 32'(reg_en), 32'd0);
    wr(2'd0, 8'h12);
    rd(2'd0, r); chk("R9 second write asleep", 32'(r), 32'h10);
    sleep_req = 1'b0;
    @(negedge clk);
    rd(2'd0, r); chk("R9 written mode after wake", 32'(r), 32'h12);
    send("R9 wake mapping", 8'h0F, 8'hFF);
  endtask

  task automatic t_stream();
    wr(2'd0, 8'h11);
    pix_out_ready = 1'b0; pix_in_valid = 1'b1; pix_in_data = 8'h0F;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h13;
    @(negedge clk);
    cfg_we = 1'b0; pix_in_valid = 1'b0;
    chk("R10 valid after accept", 32'(pix_out_valid), 32'd1);
    chk("R11 old mapping at accept", 32'(pix_out_data), 32'h0F);
    chk("R10 in_ready low in stall", 32'(pix_in_ready), 32'd0);
    wr(2'd0, 8'h12);
    @(negedge clk);
    chk("R11 held word unchanged", 32'(pix_out_data), 32'h0F);
    chk("R10 still valid in stall", 32'(pix_out_valid), 32'd1);
    pix_out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", 32'(pix_out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_forced();
    t_contrast();
    t_sleep();
    t_sleep_write();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule